// File: doc/BRIEF.md
# Special-Function Register Bank with Dual Data Pointers

This block holds the directly addressed special-function registers of a small 8-bit microcontroller core. The core presents an 8-bit direct address with a write strobe or a read strobe. Addresses 80H to FFH select registers in this bank, and read data comes back combinationally in the same cycle. Each register has its own reset value. Bits that are reserved or have no storage read as zero, and so do addresses with no register behind them.

Two 16-bit data pointers sit in the bank. A select bit chooses which one is active. The active pointer is always presented on a 16-bit output, and an increment input advances only that pointer. A power-off flag is set only by the power-on reset. Software may clear or set it, and the ordinary synchronous reset leaves it alone, so firmware can tell a cold start from a warm one. The auxiliary control bits are brought out as pins for the blocks that use them.

Timers, serial unit, port pin drivers and the CPU datapath lie outside this block. Their registers are plain storage here.

Top module: `sfr_bank`

## Requirements
- R1: After reset, registers read these values: 81H=07H; 80H, 90H, A0H, B0H=FFH; 88H-8DH, 98H, 99H, D0H, E0H, F0H, 8EH, A2H, A8H, B8H, 82H-85H=00H; 87H reads 00H except bit 4.
- R2: While `rd_en` is high, `rdata` shows the addressed register in the same cycle. While `rd_en` is low, `rdata` is 00H.
- R3: Addresses below 80H and unoccupied addresses at or above 80H always read 00H, and writes to them change no register.
- R4: Reserved bits read 0 and ignore writes. At 8EH only bits 0, 3 and 4 are stored. At A2H only bit 0 is stored. At A8H bit 6 is reserved. At B8H bits 7 and 6 are reserved. At 87H bits 6 and 5 are reserved.
- R5: Pointer 0 is read and written at 82H (low byte) and 83H (high byte). Pointer 1 is read and written at 84H (low byte) and 85H (high byte).
- R6: Bit 0 of A2H selects the active pointer: 0 selects pointer 0 and 1 selects pointer 1. `dptr_out` shows the active pointer's current value.
- R7: A cycle with `dptr_inc` high adds one, modulo 2^16, to the pointer that was active at the start of that cycle. The other pointer is unchanged. If the same cycle writes either byte of the active pointer, the write takes effect and the increment is dropped.
- R8: Bit 4 of 87H is the power-off flag. A low `por_n` sets it to 1. A low `rst_n` alone leaves it unchanged. A write to 87H loads it from `wdata[4]`.
- R9: `ale_off`, `rstout_off` and `wdt_idle_hold` follow bits 0, 3 and 4 of 8EH. `dptr_sel` follows bit 0 of A2H.
- R10: Writes take effect at the next rising clock edge. A low `por_n` also applies every reset value from R1. Both resets are synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; preserves the power-off flag |
| por_n | input | 1 | Synchronous active-low power-on reset; sets the power-off flag |
| addr | input | 8 | Direct register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Combinational read data |
| dptr_inc | input | 1 | Advance the active pointer |
| dptr_out | output | 16 | Active pointer value |
| dptr_sel | output | 1 | Current pointer select |
| ale_off | output | 1 | Address-latch pulse suppression control |
| rstout_off | output | 1 | Watchdog reset-output disable control |
| wdt_idle_hold | output | 1 | Watchdog halt-in-idle control |

## Verification
The bench aims at the cycles where two things touch one pointer. These are an increment together with a write to a byte of the active pointer, an increment in the same cycle the select bit flips, and an increment across FFFFH. A design that got these wrong would advance the idle pointer, lose the written byte, or carry into a seventeenth bit.

The bench toggles the power-off flag before each kind of reset. A bank that cleared the flag on an ordinary reset, or failed to set it on power-up, shows up at 87H.

Full-address sweeps after writing FFH everywhere expose two kinds of fault. One is a reserved bit that keeps data. The other is a gap address that aliases a real register.

// File: rtl/sfr_pkg.sv
// Shared constants and the per-address table of the plain registers.
// Assumes the bank covers the upper half of an 8-bit direct address space.
package sfr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int SLOTS  = 2 ** (ADDR_W - 1);
    localparam int PTR_W  = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] A_PTR_BASE = 8'h82;
    localparam logic [ADDR_W-1:0] A_PCON     = 8'h87;
    localparam logic [ADDR_W-1:0] A_AUX      = 8'h8E;
    localparam logic [ADDR_W-1:0] A_AUX1     = 8'hA2;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rstv;
    } slot_info_t;

    // Writable mask and reset value of each plain slot (offset from 80H).
    function automatic slot_info_t slot_info(input logic [ADDR_W-2:0] off);
        slot_info_t s;
        s = '{mask: 8'h00, rstv: 8'h00};
        case (off)
            7'h00, 7'h10, 7'h20, 7'h30: s = '{mask: 8'hFF, rstv: 8'hFF};
            7'h01:                      s = '{mask: 8'hFF, rstv: 8'h07};
            7'h08, 7'h09, 7'h0A, 7'h0B,
            7'h0C, 7'h0D, 7'h18, 7'h19,
            7'h50, 7'h60, 7'h70:        s = '{mask: 8'hFF, rstv: 8'h00};
            7'h0E:                      s = '{mask: 8'h19, rstv: 8'h00};
            7'h22:                      s = '{mask: 8'h01, rstv: 8'h00};
            7'h28:                      s = '{mask: 8'hBF, rstv: 8'h00};
            7'h38:                      s = '{mask: 8'h3F, rstv: 8'h00};
            default:                    s = '{mask: 8'h00, rstv: 8'h00};
        endcase
        return s;
    endfunction

    // Packed table of writable masks, one byte per slot.
    function automatic logic [SLOTS-1:0][DATA_W-1:0] mask_table();
        logic [SLOTS-1:0][DATA_W-1:0] t;
        for (int i = 0; i < SLOTS; i++) t[i] = slot_info(i[ADDR_W-2:0]).mask;
        return t;
    endfunction

    // Packed table of reset values, one byte per slot.
    function automatic logic [SLOTS-1:0][DATA_W-1:0] reset_table();
        logic [SLOTS-1:0][DATA_W-1:0] t;
        for (int i = 0; i < SLOTS; i++) t[i] = slot_info(i[ADDR_W-2:0]).rstv;
        return t;
    endfunction
endpackage

// File: rtl/sfr_plain_bank.sv
// Plain storage registers of the bank, each with its own reset value and mask.
// Assumes rst_n already merges both resets; unlisted slots are constant zero.
module sfr_plain_bank
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] aux_q,
    output logic              sel_q
);
    localparam logic [SLOTS-1:0][DATA_W-1:0] MASK_T = mask_table();
    localparam logic [SLOTS-1:0][DATA_W-1:0] RST_T  = reset_table();

    logic [SLOTS-1:0][DATA_W-1:0] store_q;
    logic [ADDR_W-2:0]            off;

    assign off = addr[ADDR_W-2:0];

    // Apply reset values, or a masked write to the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= RST_T;
        else if (wr_en && addr[ADDR_W-1])
            store_q[off] <= wdata & MASK_T[off];
    end

    // Return the addressed slot for upper-half addresses, zero otherwise.
    always_comb begin
        rd_data = addr[ADDR_W-1] ? store_q[off] : '0;
    end

    assign aux_q = store_q[A_AUX[ADDR_W-2:0]];
    assign sel_q = store_q[A_AUX1[ADDR_W-2:0]][0];

    // R4
    bank_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr[ADDR_W-1] |-> ((rd_data & ~MASK_T[off]) == '0));
endmodule

// File: rtl/sfr_dptr_pair.sv
// Two byte-addressable data pointers; the selected one can be incremented.
// Assumes a write to a byte of the active pointer overrides the increment.
module sfr_dptr_pair
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sel_i,
    input  logic              inc_i,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  active_o
);
    localparam int NPTR = 2;

    logic [PTR_W-1:0] ptr_arr [NPTR];
    logic [NPTR-1:0]  byte_hit;

    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
        localparam logic [ADDR_W-1:0] LO = A_PTR_BASE + ADDR_W'(2 * k);
        localparam logic [ADDR_W-1:0] HI = LO + 1'b1;
        logic [PTR_W-1:0] q;
        logic             hit_lo, hit_hi;

        assign hit_lo      = wr_en && (addr == LO);
        assign hit_hi      = wr_en && (addr == HI);
        assign byte_hit[k] = hit_lo || hit_hi;
        assign ptr_arr[k]  = q;

        // Byte writes take priority; otherwise step when this one is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (hit_lo)
                q[DATA_W-1:0] <= wdata;
            else if (hit_hi)
                q[PTR_W-1:DATA_W] <= wdata;
            else if (inc_i && (sel_i == k[0]))
                q <= q + 1'b1;
        end
    end

    // Byte read mux over the four pointer addresses.
    always_comb begin
        case (addr)
            A_PTR_BASE:        rd_data = ptr_arr[0][DATA_W-1:0];
            A_PTR_BASE + 8'd1: rd_data = ptr_arr[0][PTR_W-1:DATA_W];
            A_PTR_BASE + 8'd2: rd_data = ptr_arr[1][DATA_W-1:0];
            A_PTR_BASE + 8'd3: rd_data = ptr_arr[1][PTR_W-1:DATA_W];
            default:           rd_data = '0;
        endcase
    end

    assign active_o = ptr_arr[sel_i];

    // R7
    dptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !byte_hit[sel_i]) |=> (ptr_arr[$past(sel_i)] == $past(ptr_arr[sel_i]) + 1'b1));

    // R7
    dptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_hit[~sel_i]) |=> (ptr_arr[~$past(sel_i)] == $past(ptr_arr[~sel_i])));
endmodule

// File: rtl/sfr_pcon.sv
// Power control register with a power-off flag that only power-up sets.
// Assumes por_n has priority over rst_n; bits 6:5 are reserved.
module sfr_pcon
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] KEEP_MASK = 8'h8F;
    localparam int                FLAG_BIT  = 4;

    logic [DATA_W-1:0] ctl_q;
    logic              flag_q;
    logic              hit;

    assign hit = wr_en && (addr == A_PCON);

    // Control bits clear on either reset; software write loads them.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            ctl_q <= '0;
        else if (hit)
            ctl_q <= wdata & KEEP_MASK;
    end

    // Flag: set by power-up only, otherwise follows software writes.
    always_ff @(posedge clk) begin
        if (!por_n)
            flag_q <= 1'b1;
        else if (rst_n && hit)
            flag_q <= wdata[FLAG_BIT];
    end

    // Present the register on its own address only.
    always_comb begin
        rd_data = '0;
        if (addr == A_PCON) begin
            rd_data           = ctl_q;
            rd_data[FLAG_BIT] = flag_q;
        end
    end

    // R8
    pof_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/sfr_bank.sv
// Top of the special-function register bank: merges the sub-banks' read data
// and exports the active pointer and auxiliary control bits.
// Assumes a single strobe per cycle from the core; reads are combinational.
module sfr_bank
    import sfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        wr_en,
    input  logic        rd_en,
    output logic [7:0]  rdata,
    input  logic        dptr_inc,
    output logic [15:0] dptr_out,
    output logic        dptr_sel,
    output logic        ale_off,
    output logic        rstout_off,
    output logic        wdt_idle_hold
);
    logic              any_rst_n;
    logic [DATA_W-1:0] rd_plain, rd_ptr, rd_pcon, aux_q;
    logic              sel_q;

    assign any_rst_n = rst_n && por_n;

    sfr_plain_bank u_plain (
        .clk     (clk),
        .rst_n   (any_rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_plain),
        .aux_q   (aux_q),
        .sel_q   (sel_q)
    );

    sfr_dptr_pair u_dptr (
        .clk      (clk),
        .rst_n    (any_rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .sel_i    (sel_q),
        .inc_i    (dptr_inc),
        .rd_data  (rd_ptr),
        .active_o (dptr_out)
    );

    sfr_pcon u_pcon (
        .clk     (clk),
        .rst_n   (rst_n),
        .por_n   (por_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_pcon)
    );

    // Sub-banks return zero off their own addresses, so OR them together.
    always_comb begin
        rdata = rd_en ? (rd_plain | rd_ptr | rd_pcon) : '0;
    end

    assign dptr_sel      = sel_q;
    assign ale_off       = aux_q[0];
    assign rstout_off    = aux_q[3];
    assign wdt_idle_hold = aux_q[4];

    // R4
    auxr_rsv_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
        (rd_en && addr == A_AUX) |-> ((rdata & 8'hE6) == 8'h00));
endmodule

// File: tb/sim_sfr_bank.sv
module sim_sfr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1, por_n = 1'b0;
    logic [7:0]  addr = '0, wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, dptr_inc = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] dptr_out;
    logic        dptr_sel, ale_off, rstout_off, wdt_idle_hold;

    int checks = 0, fails = 0, cycles = 0;
    bit live = 0;
    logic [7:0] mem [256];

    always #10 clk = ~clk;

    sfr_bank u0 (.clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .dptr_inc(dptr_inc),
        .dptr_out(dptr_out), .dptr_sel(dptr_sel), .ale_off(ale_off),
        .rstout_off(rstout_off), .wdt_idle_hold(wdt_idle_hold));

    function automatic logic [7:0] wmask(input logic [7:0] a);
        case (a)
            8'h80, 8'h90, 8'hA0, 8'hB0, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85,
            8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8D, 8'h98, 8'h99,
            8'hD0, 8'hE0, 8'hF0: return 8'hFF;
            8'h87: return 8'h9F;
            8'h8E: return 8'h19;
            8'hA2: return 8'h01;
            8'hA8: return 8'hBF;
            8'hB8: return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] rval(input logic [7:0] a);
        case (a)
            8'h80, 8'h90, 8'hA0, 8'hB0: return 8'hFF;
            8'h81: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag(input logic [7:0] a);
        if (a >= 8'h82 && a <= 8'h85) return "R5";
        if (a == 8'h87) return "R8";
        if (wmask(a) == 8'h00) return "R3";
        if (wmask(a) != 8'hFF) return "R4";
        return "R2";
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", r, act, exp, cycles);
        end
    endtask

    task automatic model_reset(input bit por);
        logic [7:0] keep;
        keep = mem[8'h87] & 8'h10;
        for (int i = 0; i < 256; i++) mem[i] = rval(8'(i));
        mem[8'h87] = por ? 8'h10 : keep;
    endtask

    // One clock: drive at negedge, compare all outputs, then update the model.
    task automatic step(input logic w, input logic r, input logic [7:0] a,
                        input logic [7:0] d, input logic inc,
                        input logic rn, input logic pn, input string rtag);
        logic sel;
        logic [7:0] lo;
        logic [15:0] v;
        wr_en = w; rd_en = r; addr = a; wdata = d; dptr_inc = inc;
        rst_n = rn; por_n = pn;
        #1;
        if (live) begin
            chk((rtag != "") ? rtag : tag(a), {24'd0, rdata}, {24'd0, r ? mem[a] : 8'h00});
            sel = mem[8'hA2][0];
            // R6
            chk("R6", {16'd0, dptr_out},
                {16'd0, sel ? {mem[8'h85], mem[8'h84]} : {mem[8'h83], mem[8'h82]}});
            // R9
            chk("R9", {28'd0, dptr_sel, wdt_idle_hold, rstout_off, ale_off},
                {28'd0, sel, mem[8'h8E][4], mem[8'h8E][3], mem[8'h8E][0]});
        end
        @(posedge clk);
        cycles++;
        if (!pn) model_reset(1);
        else if (!rn) model_reset(0);
        else begin
            sel = mem[8'hA2][0];
            lo  = sel ? 8'h84 : 8'h82;
            // R7: increment dropped if active pointer byte written
            if (inc && !(w && (a == lo || a == lo + 8'd1))) begin
                v = {mem[lo + 8'd1], mem[lo]} + 16'd1;
                mem[lo] = v[7:0];
                mem[lo + 8'd1] = v[15:8];
            end
            if (w) mem[a] = d & wmask(a);
        end
        @(negedge clk);
        live = 1;
    endtask

    task automatic sweep(input string rtag);
        for (int i = 0; i < 256; i++) step(0, 1, 8'(i), 8'h00, 0, 1, 1, rtag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic inc);
        step(1, 1, a, d, inc, 1, 1, "");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        @(negedge clk);
        step(0, 0, 8'h00, 8'h00, 0, 1, 0, "");
        step(0, 0, 8'h00, 8'h00, 0, 1, 0, "");
        // R1 R10: power-up reset values
        sweep("R1");
        // R8: flag survives ordinary reset, both values
        wr(8'h87, 8'h00, 0);
        step(0, 1, 8'h87, 8'h00, 0, 0, 1, "R8");
        step(0, 1, 8'h87, 8'h00, 0, 1, 1, "R8");
        wr(8'h87, 8'h10, 0);
        step(0, 1, 8'h87, 8'h00, 0, 0, 1, "R8");
        step(0, 1, 8'h87, 8'h00, 0, 1, 1, "R8");
        // R3 R4: fill every address with FF, then read back
        for (int i = 0; i < 256; i++) wr(8'(i), 8'hFF, 0);
        sweep("R4");
        // R2: strobe low gives zero
        step(0, 0, 8'h81, 8'h00, 0, 1, 1, "R2");
        // R10: power-on resets everything, flag set
        step(0, 0, 8'h00, 8'h00, 0, 1, 0, "R10");
        sweep("R10");
        // R5 R6 R7: pointer corners
        wr(8'h82, 8'hFF, 0); wr(8'h83, 8'hFF, 0);
        step(0, 1, 8'h82, 8'h00, 1, 1, 1, "R7");   // wrap to 0000
        step(0, 1, 8'h83, 8'h00, 1, 1, 1, "R7");
        wr(8'h82, 8'h40, 1);                       // write wins over inc
        wr(8'h84, 8'h10, 1);                       // other pointer write, inc still
        wr(8'hA2, 8'h01, 1);                       // inc uses old select
        step(0, 1, 8'h84, 8'h00, 1, 1, 1, "R7");
        wr(8'h85, 8'h7F, 1);
        wr(8'hA2, 8'h00, 1);
        wr(8'h8E, 8'hFF, 0);
        wr(8'h8E, 8'h08, 0);
        // Mixed traffic with occasional resets
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            int pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1, 2: a = 8'h82 + 8'($urandom_range(0, 3));
                3:       a = 8'hA2;
                4:       a = 8'h87;
                5:       a = 8'h8E;
                default: a = 8'($urandom_range(0, 255));
            endcase
            step($urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0, a, 8'($urandom),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 150) != 0,
                 $urandom_range(0, 400) != 0, "");
        end
        sweep("R1");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule